// File: doc/BRIEF.md
# USB Packet Transmit Sequencer

This block assembles outgoing USB packets and presents them one byte at a time to a byte-wide transmit port of the kind a USB transceiver macrocell expects. It builds four packet kinds: a one-byte handshake, a three-byte token carrying a function address and endpoint, a three-byte start-of-frame token carrying an 11-bit frame number, and a data packet made of a PID byte, a streamed payload and a two-byte CRC-16. The PID check nibble, the CRC-5 of tokens and the CRC-16 of data packets are all generated inside the block. Line encoding and bit stuffing belong to the transceiver beyond the transmit port.

A packet starts with a one-cycle `start` pulse while the block is idle. The packet kind, PID, address, endpoint, frame number and the empty-payload flag are captured in that cycle. Payload bytes arrive on a valid/ready stream. Back-pressure on it comes only from the transmit side: `pl_ready` equals `tx_ready` while the payload is being sent and is low at all other times. A byte moves on a clock edge where both `pl_valid` and `pl_ready` are high. Once the payload has begun, the source must keep `pl_valid` high until the byte flagged with `pl_last` has been taken, because the transmit port cannot pause in the middle of a packet. On the transmit port, a byte is taken on every edge where `tx_valid` and `tx_ready` are both high. `tx_valid` stays high from the PID byte through the final byte.

Top module: `usb_pkt_tx`

## Requirements
- R1: While reset is asserted and right after it, `tx_valid`, `busy`, `done` and `pl_ready` are all low.
- R2: The first byte of every packet is the 4-bit PID in bits 3:0 with its bitwise complement in bits 7:4. A start-of-frame packet (kind 2'b10) always uses PID 0x5, whatever the value on `pid`.
- R3: A handshake packet (kind 2'b00) is only the PID byte. PID 0x2 is sent as 0xD2.
- R4: A token packet (kind 2'b01) has three bytes. Byte 1 is {endpoint[0], addr[6:0]}. Byte 2 is {crc5[4:0], endpoint[3:1]}, with crc5 bit 0 in byte bit 3. The CRC-5 uses polynomial x^5+x^2+1 and starts from all ones. It runs over the 11 bits {endpoint, addr}, least significant bit first, and is complemented. Address 0 with endpoint 0 gives bytes 0x00 and 0x10.
- R5: A start-of-frame packet has three bytes: frame[7:0], then {crc5[4:0], frame[10:8]}. Its CRC-5 follows the R4 rule, applied to the 11 frame bits.
- R6: A data packet (kind 2'b11) is the PID byte, the payload bytes in stream order, then two CRC bytes. The CRC-16 uses polynomial x^16+x^15+x^2+1 and starts from all ones. It runs over the payload, each byte least significant bit first, and is complemented. Its low-order byte is sent first. When `no_payload` is high at start, the payload is skipped, so DATA0 (PID 0x3) is sent as C3 00 00.
- R7: `tx_valid` stays high from the PID byte until the last byte is accepted, and falls in the cycle after that acceptance. While `tx_ready` is low, the byte on `tx_data` does not change.
- R8: `pl_ready` equals `tx_ready` while payload bytes are being sent and is low at all other times.
- R9: `busy` is high from the cycle after a start is accepted until the packet ends. A `start` that arrives while busy is ignored and does not change the packet being sent.
- R10: `done` is a one-cycle pulse in the first cycle `tx_valid` is low after a packet. A start in that cycle is accepted.
- R11: `tx_valid` rises in the cycle right after the clock edge on which a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a packet; sampled only while idle |
| pkt_kind | input | 2 | 00 handshake, 01 token, 10 start-of-frame, 11 data |
| pid | input | 4 | Packet identifier |
| func_addr | input | 7 | Token function address |
| endpoint | input | 4 | Token endpoint number |
| frame_num | input | 11 | Start-of-frame frame number |
| no_payload | input | 1 | Data packet carries no payload |
| pl_valid | input | 1 | Payload byte valid |
| pl_ready | output | 1 | Payload byte taken on this edge if valid |
| pl_data | input | 8 | Payload byte |
| pl_last | input | 1 | Marks the final payload byte |
| tx_data | output | 8 | Byte presented to the transmitter |
| tx_valid | output | 1 | Packet in progress; byte on tx_data is valid |
| tx_ready | input | 1 | Transmitter takes tx_data on this edge |
| busy | output | 1 | A packet is being sent |
| done | output | 1 | One-cycle pulse after a packet ends |

## Verification
The hardest cases to reach from the ports are starts that meet the packet boundary: a start that arrives mid-packet, and a start that arrives exactly in the `done` cycle. To reach both, the bench holds `start` high across a whole packet and changes the field inputs while busy. The held start must be ignored for the whole packet and then taken in the done cycle. The last byte is also stalled under alternating and pseudo-random `tx_ready` patterns, including on the final CRC byte. This checks that `tx_valid` falls only after the true last acceptance.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;
  localparam int BYTE_W  = 8;
  localparam int PID_W   = 4;
  localparam int ADDR_W  = 7;
  localparam int ENDP_W  = 4;
  localparam int FIELD_W = ADDR_W + ENDP_W;
  localparam int CRC5_W  = 5;
  localparam int CRC16_W = 16;

  localparam logic [CRC5_W-1:0]  CRC5_POLY_REFL  = 5'h14;
  localparam logic [CRC16_W-1:0] CRC16_POLY_REFL = 16'hA001;
  localparam logic [PID_W-1:0]   SOF_PID         = 4'h5;

  typedef enum logic [1:0] {
    PK_HSK   = 2'b00,
    PK_TOKEN = 2'b01,
    PK_SOF   = 2'b10,
    PK_DATA  = 2'b11
  } pkt_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PID,
    ST_FLD_LO,
    ST_FLD_HI,
    ST_PAYLOAD,
    ST_CRC_LO,
    ST_CRC_HI
  } tx_state_e;
endpackage

// File: rtl/usb_tx_crc_step.sv
module usb_tx_crc_step #(
  parameter int CRC_W = 5,
  parameter int DIN_W = 11,
  parameter logic [CRC_W-1:0] POLY_REFL = 5'h14
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [DIN_W-1:0] din_i,
  output logic [CRC_W-1:0] crc_o
);
  // One shift stage per input bit, least significant input bit first.
  logic [DIN_W:0][CRC_W-1:0] stage;

  assign stage[0] = crc_i;

  for (genvar i = 0; i < DIN_W; i++) begin : g_bit
    assign stage[i+1] = (stage[i][0] ^ din_i[i])
                        ? ((stage[i] >> 1) ^ POLY_REFL)
                        : (stage[i] >> 1);
  end

  assign crc_o = stage[DIN_W];
endmodule

// File: rtl/usb_tx_crc16_acc.sv
module usb_tx_crc16_acc #(
  parameter int CRC_W  = 16,
  parameter int BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY_REFL = 16'hA001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [CRC_W-BYTE_W-1:0] hi_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nxt;

  usb_tx_crc_step #(
    .CRC_W    (CRC_W),
    .DIN_W    (BYTE_W),
    .POLY_REFL(POLY_REFL)
  ) u_step (
    .crc_i(crc_q),
    .din_i(byte_i),
    .crc_o(crc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '1;
    else if (clr_i)  crc_q <= '1;
    else if (en_i)   crc_q <= crc_nxt;
  end

  // Residue goes out complemented, low-order byte first.
  assign lo_o = ~crc_q[BYTE_W-1:0];
  assign hi_o = ~crc_q[CRC_W-1:BYTE_W];
endmodule

// File: rtl/usb_tx_ctrl.sv
module usb_tx_ctrl
  import usb_tx_pkg::*;
#(
  parameter int PW = PID_W,
  parameter int AW = ADDR_W,
  parameter int EW = ENDP_W,
  parameter int FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  pkt_kind_e     kind_i,
  input  logic [PW-1:0] pid_i,
  input  logic [AW-1:0] addr_i,
  input  logic [EW-1:0] endp_i,
  input  logic [FW-1:0] frame_i,
  input  logic          no_payload_i,
  input  logic          tx_ready_i,
  input  logic          pl_valid_i,
  input  logic          pl_last_i,
  output tx_state_e     state_o,
  output logic [PW-1:0] pid_o,
  output logic [FW-1:0] field_o,
  output logic          tx_valid_o,
  output logic          busy_o,
  output logic          done_o
);
  tx_state_e     state_q, state_d;
  pkt_kind_e     kind_q;
  logic [PW-1:0] pid_q;
  logic [FW-1:0] field_q;
  logic          empty_q;
  logic          done_q;
  logic          accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_PID;
      ST_PID:
        if (tx_ready_i) begin
          unique case (kind_q)
            PK_HSK:          state_d = ST_IDLE;
            PK_TOKEN, PK_SOF: state_d = ST_FLD_LO;
            default:         state_d = empty_q ? ST_CRC_LO : ST_PAYLOAD;
          endcase
        end
      ST_FLD_LO:  if (tx_ready_i) state_d = ST_FLD_HI;
      ST_FLD_HI:  if (tx_ready_i) state_d = ST_IDLE;
      ST_PAYLOAD: if (tx_ready_i && pl_valid_i && pl_last_i) state_d = ST_CRC_LO;
      ST_CRC_LO:  if (tx_ready_i) state_d = ST_CRC_HI;
      ST_CRC_HI:  if (tx_ready_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= PK_HSK;
      pid_q   <= '0;
      field_q <= '0;
      empty_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
      if (accept) begin
        kind_q  <= kind_i;
        pid_q   <= (kind_i == PK_SOF) ? SOF_PID : pid_i;
        field_q <= (kind_i == PK_SOF) ? frame_i : {endp_i, addr_i};
        empty_q <= no_payload_i;
      end
    end
  end

  assign state_o    = state_q;
  assign pid_o      = pid_q;
  assign field_o    = field_q;
  assign tx_valid_o = (state_q != ST_IDLE);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

  // R7: a byte that is not taken keeps the packet open
  assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o);

  // R10: the end of a packet is always announced
  assert_done_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_valid_o) |-> done_o);

  // R10: done never overlaps an open packet
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !tx_valid_o);

  // R9: a start while busy leaves the captured packet untouched
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(field_q) && $stable(pid_q) && $stable(kind_q));

  // R8: the payload source may not stall mid-packet
  assert_stream_nostall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_PAYLOAD |-> pl_valid_i);
endmodule

// File: rtl/usb_pkt_tx.sv
module usb_pkt_tx
  import usb_tx_pkg::*;
#(
  parameter int BW  = BYTE_W,
  parameter int PW  = PID_W,
  parameter int AW  = ADDR_W,
  parameter int EW  = ENDP_W,
  parameter int C5W = CRC5_W,
  parameter int C16W = CRC16_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    pkt_kind,
  input  logic [PW-1:0] pid,
  input  logic [AW-1:0] func_addr,
  input  logic [EW-1:0] endpoint,
  input  logic [AW+EW-1:0] frame_num,
  input  logic          no_payload,
  input  logic          pl_valid,
  output logic          pl_ready,
  input  logic [BW-1:0] pl_data,
  input  logic          pl_last,
  output logic [BW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          busy,
  output logic          done
);
  localparam int FW = AW + EW;

  tx_state_e       state;
  logic [PW-1:0]   pid_q;
  logic [FW-1:0]   field_q;
  logic [C5W-1:0]  crc5_raw;
  logic [BW-1:0]   crc16_lo;
  logic [C16W-BW-1:0] crc16_hi;
  logic            in_payload;

  usb_tx_ctrl #(.PW(PW), .AW(AW), .EW(EW), .FW(FW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .kind_i      (pkt_kind_e'(pkt_kind)),
    .pid_i       (pid),
    .addr_i      (func_addr),
    .endp_i      (endpoint),
    .frame_i     (frame_num),
    .no_payload_i(no_payload),
    .tx_ready_i  (tx_ready),
    .pl_valid_i  (pl_valid),
    .pl_last_i   (pl_last),
    .state_o     (state),
    .pid_o       (pid_q),
    .field_o     (field_q),
    .tx_valid_o  (tx_valid),
    .busy_o      (busy),
    .done_o      (done)
  );

  usb_tx_crc_step #(
    .CRC_W    (C5W),
    .DIN_W    (FW),
    .POLY_REFL(CRC5_POLY_REFL)
  ) u_crc5 (
    .crc_i('1),
    .din_i(field_q),
    .crc_o(crc5_raw)
  );

  assign in_payload = (state == ST_PAYLOAD);
  assign pl_ready   = in_payload && tx_ready;

  usb_tx_crc16_acc #(
    .CRC_W    (C16W),
    .BYTE_W   (BW),
    .POLY_REFL(CRC16_POLY_REFL)
  ) u_crc16 (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (state == ST_IDLE),
    .en_i  (in_payload && tx_ready && pl_valid),
    .byte_i(pl_data),
    .lo_o  (crc16_lo),
    .hi_o  (crc16_hi)
  );

  always_comb begin
    unique case (state)
      ST_PID:     tx_data = {~pid_q, pid_q};
      ST_FLD_LO:  tx_data = field_q[BW-1:0];
      ST_FLD_HI:  tx_data = {~crc5_raw, field_q[FW-1:BW]};
      ST_PAYLOAD: tx_data = pl_data;
      ST_CRC_LO:  tx_data = crc16_lo;
      ST_CRC_HI:  tx_data = crc16_hi;
      default:    tx_data = '0;
    endcase
  end

  // R8: payload is only drawn while the transmitter is taking bytes
  assert_payload_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> tx_valid && tx_ready);

  // R6: every data packet starts its CRC-16 from the all-ones seed
  assert_crc16_seed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PID |-> (crc16_lo == '0) && (crc16_hi == '0));

  // R11: an accepted start opens the packet on the next cycle
  assert_valid_after_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid && start |=> tx_valid);
endmodule

// File: tb/usb_pkt_tx_bench.sv
`timescale 1ns/1ps
module usb_pkt_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  pkt_kind = 2'b00;
  logic [3:0]  pid = 4'h0;
  logic [6:0]  func_addr = '0;
  logic [3:0]  endpoint = '0;
  logic [10:0] frame_num = '0;
  logic        no_payload = 1'b0;
  logic        pl_valid = 1'b1;
  logic        pl_ready;
  logic [7:0]  pl_data;
  logic        pl_last;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic        busy, done;

  usb_pkt_tx u_usb_pkt_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_kind(pkt_kind), .pid(pid),
    .func_addr(func_addr), .endpoint(endpoint), .frame_num(frame_num),
    .no_payload(no_payload), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .pl_data(pl_data), .pl_last(pl_last), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int rdy_mode = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Payload source
  logic [7:0] pay [64];
  int plen = 0;
  int pidx = 0;
  assign pl_data = pay[pidx % 64];
  assign pl_last = (pidx == plen - 1);
  always @(posedge clk) if (pl_ready && pl_valid) pidx <= pidx + 1;

  // Reference CRCs, written in shift-left form with reflected results.
  function automatic logic [4:0] ref_crc5(input logic [10:0] f);
    logic [4:0] c = 5'h1F;
    logic [4:0] r;
    logic [4:0] o;
    for (int i = 0; i < 11; i++) begin
      logic fb = c[4] ^ f[i];
      c = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'h05;
    end
    r = ~c;
    for (int k = 0; k < 5; k++) o[k] = r[4-k];
    return o;
  endfunction

  function automatic logic [15:0] ref_crc16(input int n);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] r;
    logic [15:0] o;
    for (int j = 0; j < n; j++)
      for (int i = 0; i < 8; i++) begin
        logic fb = c[15] ^ pay[j][i];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h8005;
      end
    r = ~c;
    for (int k = 0; k < 16; k++) o[k] = r[15-k];
    return o;
  endfunction

  // Cycle model
  logic [7:0] m_q[$];
  bit m_active = 0, m_done = 0;
  int m_pos = 0, m_plen = 0, m_kind = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_active = 0; m_done = 0; m_pos = 0;
    end else begin
      m_done = 0;
      if (m_active) begin
        if (tx_ready) begin
          void'(m_q.pop_front());
          m_pos++;
          if (m_q.size() == 0) begin m_active = 0; m_done = 1; end
        end
      end else if (start) begin
        logic [3:0] p;
        logic [10:0] f;
        logic [15:0] c16;
        m_q.delete();
        m_kind = pkt_kind;
        m_plen = 0;
        p = (pkt_kind == 2'b10) ? 4'h5 : pid;
        m_q.push_back({~p, p});
        if (pkt_kind == 2'b01 || pkt_kind == 2'b10) begin
          f = (pkt_kind == 2'b10) ? frame_num : {endpoint, func_addr};
          m_q.push_back(f[7:0]);
          m_q.push_back({ref_crc5(f), f[10:8]});
        end else if (pkt_kind == 2'b11) begin
          m_plen = no_payload ? 0 : plen;
          for (int j = 0; j < m_plen; j++) m_q.push_back(pay[j]);
          c16 = ref_crc16(m_plen);
          m_q.push_back(c16[7:0]);
          m_q.push_back(c16[15:8]);
        end
        m_active = 1;
        m_pos = 0;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_plr;
      string tag;
      chk(tx_valid == m_active, "R7 R11 tx_valid", tx_valid, m_active);
      chk(busy == m_active, "R9 busy", busy, m_active);
      chk(done == m_done, "R10 done", done, m_done);
      exp_plr = m_active && m_kind == 3 && m_pos >= 1 && m_pos <= m_plen && tx_ready;
      chk(pl_ready == exp_plr, "R8 pl_ready", pl_ready, exp_plr);
      if (m_active) begin
        if (m_pos == 0) tag = "R2 pid byte";
        else if (m_kind == 0) tag = "R3 handshake";
        else if (m_kind == 1) tag = "R4 token";
        else if (m_kind == 2) tag = "R5 sof";
        else tag = "R6 data";
        chk(tx_data == m_q[0], tag, tx_data, m_q[0]);
      end
    end
  end

  // Byte capture of accepted bytes
  logic [7:0] cap[$];
  always @(posedge clk) if (rst_n && tx_valid && tx_ready) cap.push_back(tx_data);

  // tx_ready driver
  initial begin
    forever begin
      @(posedge clk); #4;
      case (rdy_mode)
        0: tx_ready = 1'b1;
        1: tx_ready = ~tx_ready;
        default: tx_ready = ($urandom % 3) != 0;
      endcase
    end
  end

  task automatic setup(input int k, input logic [3:0] p, input logic [6:0] a,
                       input logic [3:0] e, input logic [10:0] fr, input bit emp, input int n);
    @(posedge clk); #4;
    pkt_kind = k[1:0]; pid = p; func_addr = a; endpoint = e; frame_num = fr;
    no_payload = emp; plen = n; pidx = 0;
    cap.delete();
  endtask

  task automatic pulse_start();
    @(posedge clk); #4 start = 1'b1;
    @(posedge clk); #4 start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic run(input int k, input logic [3:0] p, input logic [6:0] a,
                     input logic [3:0] e, input logic [10:0] fr, input bit emp, input int n);
    setup(k, p, a, e, fr, emp, n);
    pulse_start();
    wait_done();
  endtask

  initial begin
    repeat (64000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) pay[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk(!tx_valid && !busy && !done && !pl_ready, "R1 reset outputs", {tx_valid, busy, done, pl_ready}, 0);
    @(posedge clk); #4 rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !busy && !done && !pl_ready, "R1 after reset", {tx_valid, busy, done, pl_ready}, 0);

    // R3 ACK handshake
    run(0, 4'h2, 0, 0, 0, 0, 0);
    chk(cap.size() == 1 && cap[0] == 8'hD2, "R3 ACK byte", cap[0], 8'hD2);

    // R4 known token bytes
    run(1, 4'hD, 7'h00, 4'h0, 0, 0, 0);
    chk(cap.size() == 3 && cap[0] == 8'h2D && cap[1] == 8'h00 && cap[2] == 8'h10,
        "R4 token addr0 ep0", {cap[0], cap[1], cap[2]}, 24'h2D0010);

    rdy_mode = 1;
    run(1, 4'h1, 7'h12, 4'h1, 0, 0, 0);
    run(1, 4'h9, 7'h7F, 4'hF, 0, 0, 0);

    // R5 start-of-frame, pid input overridden
    rdy_mode = 2;
    run(2, 4'h9, 0, 0, 11'h000, 0, 0);
    chk(cap.size() == 3 && cap[0] == 8'hA5, "R5 R2 sof pid", cap[0], 8'hA5);
    run(2, 4'h0, 0, 0, 11'h7FF, 0, 0);
    run(2, 4'h0, 0, 0, 11'h2A5, 0, 0);

    // R6 empty DATA0
    rdy_mode = 0;
    run(3, 4'h3, 0, 0, 0, 1, 5);
    chk(cap.size() == 3 && cap[0] == 8'hC3 && cap[1] == 8'h00 && cap[2] == 8'h00,
        "R6 empty DATA0", {cap[0], cap[1], cap[2]}, 24'hC30000);

    run(3, 4'hB, 0, 0, 0, 0, 1);
    rdy_mode = 1;
    run(3, 4'hB, 0, 0, 0, 0, 8);
    rdy_mode = 2;
    run(3, 4'h3, 0, 0, 0, 0, 64);
    chk(cap.size() == 67, "R6 64-byte length", cap.size(), 67);

    // R9 start pulse while busy is ignored
    setup(3, 4'h3, 0, 0, 0, 0, 8);
    pulse_start();
    repeat (3) @(posedge clk);
    #4 pkt_kind = 2'b00; pid = 4'hA; start = 1'b1;
    @(posedge clk); #4 start = 1'b0;
    wait_done();
    chk(cap.size() == 11, "R9 busy start ignored", cap.size(), 11);
    repeat (4) @(negedge clk);
    chk(!tx_valid, "R9 no extra packet", tx_valid, 0);

    // R10 start held high: ignored while busy, accepted in the done cycle
    rdy_mode = 2;
    setup(1, 4'h1, 7'h05, 4'h3, 0, 0, 0);
    @(posedge clk); #4 start = 1'b1;
    @(posedge clk); #4 func_addr = 7'h33; endpoint = 4'h6; pid = 4'h9;
    wait_done();
    @(posedge clk); #4 start = 1'b0;
    chk(tx_valid, "R10 start in done cycle", tx_valid, 1);
    wait_done();
    rdy_mode = 0;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule